// File: doc/BRIEF.md
# SMRAM Control Register and Address Remapper

This block holds the 8-bit control byte that governs extended system-management memory, and applies that control to a live CPU access stream. Software reads and writes the byte through a plain register port at offset 0x61. The byte holds two enables: one for the high SMRAM alias and one for a 1 MB TSEG window. It also holds a sticky violation flag and a few fixed bits. A lock input freezes both enables until the next reset. A global SMRAM enable gates both windows.

Each CPU access carries an address, a valid strobe and a flag that says the CPU is in SMM. The block registers each access once. Accesses that land in the high SMRAM alias come out redirected to the legacy low SMRAM area. All other addresses come out unchanged. Hits in the TSEG window are flagged. The violation flag is set when an active window is touched from outside SMM, and it stays set until software writes a one to it.

Top module: `smram_ctl`

## Requirements
- R1: After a synchronous reset, a read at offset 0x61 returns 0x38. A read at any other offset returns 0x00, and a write at any other offset changes nothing.
- R2: Bits 5, 4 and 3 always read as 1, and bits 2 and 1 always read as 0, whatever value is written.
- R3: While unlocked, a write at offset 0x61 loads bit 7 (high SMRAM enable) and bit 0 (TSEG enable) from the write data. The new value is visible on the read port in the cycle after the write.
- R4: Once lock_in has been high in any cycle, including the cycle of the write itself, writes no longer change bit 7 or bit 0. This holds until reset, even after lock_in falls.
- R5: When smram_en, bit 7 and acc_valid are all 1 and acc_addr is in 0xFEDA0000..0xFEDBFFFF, out_addr one cycle later is 0x000A0000 + (acc_addr - 0xFEDA0000).
- R6: Every other access appears unchanged on out_addr one cycle later. out_valid is acc_valid delayed by one cycle.
- R7: out_tseg_hit is 1 one cycle after a valid access when smram_en and bit 0 are 1 and acc_addr is in tseg_base..tseg_base+0xFFFFF. Otherwise it is 0.
- R8: A valid access with acc_in_smm low that hits an active high SMRAM or TSEG window sets bit 6 in the next cycle. The same access with acc_in_smm high, or an access outside any active window, leaves bit 6 unchanged.
- R9: A write with bit 6 = 1 at offset 0x61 clears bit 6, and a write with bit 6 = 0 leaves it set. Clearing works with the lock in force.
- R10: If a violation and a clearing write happen in the same cycle, bit 6 ends up set.
- R11: err_flag always equals bit 6 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Register offset for reads and writes |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| lock_in | input | 1 | Lock request, held internally until reset |
| smram_en | input | 1 | Global SMRAM enable |
| tseg_base | input | 32 | TSEG base address, 1 MB aligned |
| acc_valid | input | 1 | CPU access strobe |
| acc_addr | input | 32 | CPU access address |
| acc_in_smm | input | 1 | Access is made from SMM |
| out_valid | output | 1 | Registered access strobe |
| out_addr | output | 32 | Registered, remapped DRAM address |
| out_tseg_hit | output | 1 | Registered TSEG window hit |
| err_flag | output | 1 | Sticky out-of-SMM violation flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 17-bit high SMRAM window and a 20-bit TSEG window. It drives tseg_base with 0x7F000000. With these values, the exact first and last addresses of both windows can be probed, together with the addresses one step outside them. The bench also steps through the lock before and after reset, and it lines up a violation with a clearing write in the same cycle.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_HI   = 7;
    localparam int BIT_ERR  = 6;
    localparam int BIT_TSEG = 0;
    localparam logic [2:0] FIXED_ONES = 3'b111;

    typedef struct packed {
        logic hi_en;
        logic err;
        logic tseg_en;
    } smram_ctl_t;

    localparam smram_ctl_t CTL_RESET = '{hi_en: 1'b0, err: 1'b0, tseg_en: 1'b0};

    typedef struct packed {
        logic hi_hit;
        logic tseg_hit;
        logic viol;
    } win_hit_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_LOCKED,
        WR_OPEN
    } wr_kind_t;

    function automatic logic [REG_W-1:0] ctl_to_byte(smram_ctl_t c);
        logic [REG_W-1:0] b;
        b           = '0;
        b[BIT_HI]   = c.hi_en;
        b[BIT_ERR]  = c.err;
        b[5:3]      = FIXED_ONES;
        b[BIT_TSEG] = c.tseg_en;
        return b;
    endfunction

endpackage

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
    import smram_pkg::*;
#(
    parameter int                CFG_AW  = 8,
    parameter logic [CFG_AW-1:0] REG_OFS = 8'h61
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              lock_in,
    input  logic              viol,
    output smram_ctl_t        ctl_o,
    output logic [REG_W-1:0]  cfg_rdata
);

    smram_ctl_t ctl_q;
    logic       lock_q;
    logic       lock_eff;
    logic       sel;
    logic       err_clr;
    wr_kind_t   wr_kind;
    logic       unused_wbits;

    assign unused_wbits = ^cfg_wdata[5:1];

    assign sel      = (cfg_addr == REG_OFS);
    assign lock_eff = lock_q | lock_in;
    assign err_clr  = cfg_we & sel & cfg_wdata[BIT_ERR];

    always_comb begin
        if (!(cfg_we && sel))
            wr_kind = WR_NONE;
        else if (lock_eff)
            wr_kind = WR_LOCKED;
        else
            wr_kind = WR_OPEN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_RESET;
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_eff;
            if (wr_kind == WR_OPEN) begin
                ctl_q.hi_en   <= cfg_wdata[BIT_HI];
                ctl_q.tseg_en <= cfg_wdata[BIT_TSEG];
            end
            if (viol)
                ctl_q.err <= 1'b1;
            else if (err_clr)
                ctl_q.err <= 1'b0;
        end
    end

    assign ctl_o     = ctl_q;
    assign cfg_rdata = sel ? ctl_to_byte(ctl_q) : '0;

    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R4
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_in || lock_q) |=> ($stable(ctl_q.hi_en) && $stable(ctl_q.tseg_en)));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> ctl_q.err);

    // R9
    err_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.err && !err_clr) |=> ctl_q.err);

endmodule

// File: rtl/smram_win_dec.sv
module smram_win_dec
    import smram_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                HI_WIN_BITS   = 17,
    parameter int                TSEG_WIN_BITS = 20,
    parameter logic [ADDR_W-1:0] HI_SRC_BASE   = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0] HI_DST_BASE   = 32'h000A_0000
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_in_smm,
    input  logic              glb_en,
    input  logic              hi_en,
    input  logic              tseg_en,
    input  logic [ADDR_W-1:0] tseg_base,
    output win_hit_t          hit,
    output logic [ADDR_W-1:0] map_addr
);

    localparam int HI_TAG_W   = ADDR_W - HI_WIN_BITS;
    localparam int TSEG_TAG_W = ADDR_W - TSEG_WIN_BITS;

    logic [HI_TAG_W-1:0]   hi_tag;
    logic [TSEG_TAG_W-1:0] tseg_tag;
    logic                  hi_match;
    logic                  tseg_match;
    logic                  unused_base_low;

    assign unused_base_low = ^tseg_base[TSEG_WIN_BITS-1:0];

    assign hi_tag     = acc_addr[ADDR_W-1:HI_WIN_BITS];
    assign tseg_tag   = acc_addr[ADDR_W-1:TSEG_WIN_BITS];
    assign hi_match   = (hi_tag == HI_SRC_BASE[ADDR_W-1:HI_WIN_BITS]);
    assign tseg_match = (tseg_tag == tseg_base[ADDR_W-1:TSEG_WIN_BITS]);

    always_comb begin
        hit.hi_hit   = acc_valid & glb_en & hi_en   & hi_match;
        hit.tseg_hit = acc_valid & glb_en & tseg_en & tseg_match;
        hit.viol     = (hit.hi_hit | hit.tseg_hit) & ~acc_in_smm;
    end

    always_comb begin
        if (hit.hi_hit)
            map_addr = {HI_DST_BASE[ADDR_W-1:HI_WIN_BITS], acc_addr[HI_WIN_BITS-1:0]};
        else
            map_addr = acc_addr;
    end

endmodule

// File: rtl/smram_out_stage.sv
module smram_out_stage #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_tseg,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_tseg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_tseg  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_addr  <= in_addr;
            out_tseg  <= in_tseg & in_valid;
        end
    end

    // R7
    tseg_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_tseg |-> out_valid);

endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
    import smram_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                CFG_AW        = 8,
    parameter logic [CFG_AW-1:0] REG_OFS       = 8'h61,
    parameter int                HI_WIN_BITS   = 17,
    parameter int                TSEG_WIN_BITS = 20,
    parameter logic [ADDR_W-1:0] HI_SRC_BASE   = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0] HI_DST_BASE   = 32'h000A_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              lock_in,
    input  logic              smram_en,
    input  logic [ADDR_W-1:0] tseg_base,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_in_smm,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_tseg_hit,
    output logic              err_flag
);

    smram_ctl_t        ctl;
    win_hit_t          hit;
    logic [ADDR_W-1:0] map_addr;

    smram_ctl_reg #(
        .CFG_AW (CFG_AW),
        .REG_OFS(REG_OFS)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .cfg_addr (cfg_addr),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .lock_in  (lock_in),
        .viol     (hit.viol),
        .ctl_o    (ctl),
        .cfg_rdata(cfg_rdata)
    );

    smram_win_dec #(
        .ADDR_W       (ADDR_W),
        .HI_WIN_BITS  (HI_WIN_BITS),
        .TSEG_WIN_BITS(TSEG_WIN_BITS),
        .HI_SRC_BASE  (HI_SRC_BASE),
        .HI_DST_BASE  (HI_DST_BASE)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_in_smm(acc_in_smm),
        .glb_en    (smram_en),
        .hi_en     (ctl.hi_en),
        .tseg_en   (ctl.tseg_en),
        .tseg_base (tseg_base),
        .hit       (hit),
        .map_addr  (map_addr)
    );

    smram_out_stage #(
        .ADDR_W(ADDR_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (acc_valid),
        .in_addr  (map_addr),
        .in_tseg  (hit.tseg_hit),
        .out_valid(out_valid),
        .out_addr (out_addr),
        .out_tseg (out_tseg_hit)
    );

    assign err_flag = ctl.err;

    // R5
    hi_remap_chk: assert property (@(posedge clk) disable iff (rst)
        hit.hi_hit |=> (out_addr == {HI_DST_BASE[ADDR_W-1:HI_WIN_BITS],
                                     $past(acc_addr[HI_WIN_BITS-1:0])}));

    // R6
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !hit.hi_hit) |=> (out_addr == $past(acc_addr)));

    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> out_valid);

    // R8
    viol_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_in_smm && !err_flag && !cfg_we) |=> !err_flag);

    // R11
    err_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == REG_OFS) |-> (cfg_rdata[BIT_ERR] == err_flag));

endmodule

// File: tb/smram_ctl_bench.sv
module smram_ctl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_addr;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        lock_in;
    logic        smram_en;
    logic [31:0] tseg_base;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_in_smm;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_tseg_hit;
    logic        err_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_ctl u_smram_ctl (
        .clk         (clk),
        .rst         (rst),
        .cfg_addr    (cfg_addr),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .lock_in     (lock_in),
        .smram_en    (smram_en),
        .tseg_base   (tseg_base),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_in_smm  (acc_in_smm),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_tseg_hit(out_tseg_hit),
        .err_flag    (err_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] ofs, logic [7:0] d);
        cfg_addr  = ofs;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        tick();
        cfg_we    = 1'b0;
        cfg_addr  = 8'h61;
    endtask

    task automatic reg_read(logic [7:0] ofs, output logic [7:0] d);
        cfg_addr = ofs;
        #1;
        d = cfg_rdata;
        cfg_addr = 8'h61;
        #1;
    endtask

    task automatic access(logic [31:0] a, logic smm);
        acc_addr   = a;
        acc_in_smm = smm;
        acc_valid  = 1'b1;
        tick();
        acc_valid  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        reg_read(8'h61, d);
        chk("R1", "reset value", {24'h0, d}, 32'h38);
        reg_read(8'h60, d);
        chk("R1", "other offset read", {24'h0, d}, 32'h0);
        chk("R11", "err after reset", {31'h0, err_flag}, 32'h0);
        chk("R6", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        reg_write(8'h62, 8'h81);
        reg_read(8'h61, d);
        chk("R1", "write to other offset ignored", {24'h0, d}, 32'h38);
    endtask

    task automatic t_bits();
        logic [7:0] d;
        reg_write(8'h61, 8'h06);
        reg_read(8'h61, d);
        chk("R2", "fixed bits after 0x06", {24'h0, d}, 32'h38);
        reg_write(8'h61, 8'hFF);
        reg_read(8'h61, d);
        chk("R3", "enables set", {24'h0, d}, 32'hB9);
        reg_write(8'h61, 8'h00);
        reg_read(8'h61, d);
        chk("R3", "enables cleared", {24'h0, d}, 32'h38);
    endtask

    task automatic t_remap();
        reg_write(8'h61, 8'h80);
        smram_en = 1'b1;
        access(32'hFEDA_0000, 1'b1);
        chk("R5", "remap low edge", out_addr, 32'h000A_0000);
        chk("R6", "out_valid with access", {31'h0, out_valid}, 32'h1);
        access(32'hFEDB_FFFF, 1'b1);
        chk("R5", "remap high edge", out_addr, 32'h000B_FFFF);
        access(32'hFEDA_1234, 1'b1);
        chk("R5", "remap middle", out_addr, 32'h000A_1234);
        chk("R8", "no error in SMM", {31'h0, err_flag}, 32'h0);
    endtask

    task automatic t_passthru();
        access(32'hFEDC_0000, 1'b1);
        chk("R6", "above window", out_addr, 32'hFEDC_0000);
        access(32'hFED9_FFFF, 1'b1);
        chk("R6", "below window", out_addr, 32'hFED9_FFFF);
        smram_en = 1'b0;
        access(32'hFEDA_0000, 1'b1);
        chk("R6", "global enable off", out_addr, 32'hFEDA_0000);
        smram_en = 1'b1;
        reg_write(8'h61, 8'h00);
        access(32'hFEDA_0004, 1'b1);
        chk("R6", "bit 7 off", out_addr, 32'hFEDA_0004);
        tick();
        chk("R6", "out_valid idle", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic t_tseg();
        tseg_base = 32'h7F00_0000;
        reg_write(8'h61, 8'h01);
        access(32'h7F00_0000, 1'b1);
        chk("R7", "tseg base", {31'h0, out_tseg_hit}, 32'h1);
        access(32'h7F0F_FFFF, 1'b1);
        chk("R7", "tseg last", {31'h0, out_tseg_hit}, 32'h1);
        chk("R6", "tseg address unchanged", out_addr, 32'h7F0F_FFFF);
        access(32'h7F10_0000, 1'b1);
        chk("R7", "tseg past end", {31'h0, out_tseg_hit}, 32'h0);
        access(32'h7EFF_FFFF, 1'b1);
        chk("R7", "tseg below base", {31'h0, out_tseg_hit}, 32'h0);
        smram_en = 1'b0;
        access(32'h7F00_0000, 1'b1);
        chk("R7", "tseg global off", {31'h0, out_tseg_hit}, 32'h0);
        smram_en = 1'b1;
        tick();
        chk("R7", "tseg no access", {31'h0, out_tseg_hit}, 32'h0);
    endtask

    task automatic t_err();
        logic [7:0] d;
        reg_write(8'h61, 8'h81);
        access(32'hFEDA_0100, 1'b0);
        chk("R8", "high window violation", {31'h0, err_flag}, 32'h1);
        reg_read(8'h61, d);
        chk("R11", "bit 6 visible", {24'h0, d}, 32'hF9);
        reg_write(8'h61, 8'h81);
        chk("R9", "write 0 keeps flag", {31'h0, err_flag}, 32'h1);
        reg_write(8'h61, 8'hC1);
        chk("R9", "write 1 clears flag", {31'h0, err_flag}, 32'h0);
        access(32'h7F05_0000, 1'b0);
        chk("R8", "tseg violation", {31'h0, err_flag}, 32'h1);
        reg_write(8'h61, 8'hC1);
        access(32'h1234_5678, 1'b0);
        chk("R8", "outside windows", {31'h0, err_flag}, 32'h0);
        access(32'h7F05_0000, 1'b1);
        chk("R8", "tseg in SMM", {31'h0, err_flag}, 32'h0);
    endtask

    task automatic t_set_wins();
        cfg_addr   = 8'h61;
        cfg_wdata  = 8'hC1;
        cfg_we     = 1'b1;
        acc_addr   = 32'hFEDA_0000;
        acc_in_smm = 1'b0;
        acc_valid  = 1'b1;
        tick();
        cfg_we     = 1'b0;
        acc_valid  = 1'b0;
        chk("R10", "set beats clear", {31'h0, err_flag}, 32'h1);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        reg_write(8'h61, 8'hC1);
        reg_read(8'h61, d);
        chk("R9", "cleared before lock", {24'h0, d}, 32'hB9);
        lock_in = 1'b1;
        reg_write(8'h61, 8'h00);
        lock_in = 1'b0;
        reg_read(8'h61, d);
        chk("R4", "write with lock ignored", {24'h0, d}, 32'hB9);
        reg_write(8'h61, 8'h00);
        reg_read(8'h61, d);
        chk("R4", "lock held after drop", {24'h0, d}, 32'hB9);
        access(32'hFEDA_0000, 1'b0);
        chk("R8", "violation under lock", {31'h0, err_flag}, 32'h1);
        reg_write(8'h61, 8'h40);
        reg_read(8'h61, d);
        chk("R9", "clear under lock", {24'h0, d}, 32'hB9);
        do_reset();
        reg_write(8'h61, 8'h80);
        reg_read(8'h61, d);
        chk("R4", "reset releases lock", {24'h0, d}, 32'hB8);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        cfg_addr   = 8'h61;
        cfg_we     = 1'b0;
        cfg_wdata  = 8'h00;
        lock_in    = 1'b0;
        smram_en   = 1'b0;
        tseg_base  = 32'h7F00_0000;
        acc_valid  = 1'b0;
        acc_addr   = 32'h0;
        acc_in_smm = 1'b1;
        t_reset();
        t_bits();
        t_remap();
        t_passthru();
        t_tseg();
        t_err();
        t_set_wins();
        t_lock();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule